// File: doc/BRIEF.md
# Software Interrupt Pending Tracker

This block keeps the pending and active state of software-generated interrupts inside a multi-core interrupt distributor. A CPU raises interrupt `id` toward any set of target CPUs. For every combination of interrupt number, source CPU and target CPU there is one pending bit, so the block remembers which CPUs asked for the interrupt, and not only that someone did.

Each target CPU acknowledges through its own request pin. One cycle later it receives the interrupt number and the source CPU that it is now servicing. The acknowledge clears only the bit of that one source, and the interrupt becomes active for that target until the target signals end-of-interrupt.

Software can also set or clear single per-source bits through two write ports. The per-interrupt, per-target summary outputs are derived values and have no write path. The raise port is a valid/ready stream. `rq_ready` is always high, so a raise is accepted in every cycle that `rq_valid` is high, and the block never applies back-pressure.

Top module: `sgi_pend_tracker`

## Requirements
- R1: A raise (`rq_valid`) sets the pending bit (interrupt `rq_id`, source `rq_src`, target t) for every t with `rq_tgt[t]` = 1, one clock after the raise, and leaves every other bit untouched. `rq_ready` is always 1.
- R2: `pend_sum[id*NCPU + t]` is 1 exactly when at least one source's pending bit for interrupt `id` and target `t` is set.
- R3: `sp_valid` sets and `cp_valid` clears the single bit (`*_id`, `*_src`, `*_tgt`), one clock later. Clearing one source's bit leaves the summary asserted when another source's bit is still set.
- R4: On `ack_req[t]`, the block picks the lowest-numbered interrupt whose summary for `t` is set and which is not active for `t`. From that interrupt it picks the lowest-numbered pending source, and it clears only that source's bit.
- R5: After an acknowledge that clears one of several source bits, `pend_sum` for that interrupt and target stays 1.
- R6: `rsp_valid[t]` is 1 exactly one clock after `ack_req[t]`. `rsp_id` and `rsp_src` (slices `t*IW` and `t*SW`) give the chosen interrupt and source, with `rsp_hit[t]` = 1. When nothing is eligible, `rsp_hit[t]` = 0 and both fields are 0.
- R7: A successful acknowledge sets `act[id*NCPU + t]`. An active interrupt is never chosen for that target. `eoi_valid[t]` with `eoi_id` (slice `t*IW`) clears that active bit one clock later.
- R8: When a set (raise or `sp_valid`) and a clear (acknowledge or `cp_valid`) hit the same bit in the same cycle, the set wins.
- R9: Synchronous active-high `rst` clears all pending bits, all active bits and all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rq_valid | input | 1 | Raise request valid |
| rq_ready | output | 1 | Raise request ready (always 1) |
| rq_src | input | SW | Raising CPU |
| rq_id | input | IW | Interrupt number raised |
| rq_tgt | input | NCPU | Target CPU mask |
| sp_valid | input | 1 | Set one per-source bit |
| sp_id | input | IW | Interrupt of bit to set |
| sp_src | input | SW | Source of bit to set |
| sp_tgt | input | SW | Target of bit to set |
| cp_valid | input | 1 | Clear one per-source bit |
| cp_id | input | IW | Interrupt of bit to clear |
| cp_src | input | SW | Source of bit to clear |
| cp_tgt | input | SW | Target of bit to clear |
| ack_req | input | NCPU | Acknowledge request per target |
| rsp_valid | output | NCPU | Acknowledge response valid |
| rsp_hit | output | NCPU | Response carries an interrupt |
| rsp_id | output | NCPU*IW | Acknowledged interrupt per target |
| rsp_src | output | NCPU*SW | Source CPU per target |
| eoi_valid | input | NCPU | End-of-interrupt per target |
| eoi_id | input | NCPU*IW | Interrupt being completed per target |
| pend_sum | output | NSGI*NCPU | Summary pending, index id*NCPU+t |
| act | output | NSGI*NCPU | Active state, index id*NCPU+t |

## Verification
The bench raises one interrupt from two sources toward the same target and acknowledges twice. A tracker that kept one pending bit per target would lose the second source after the first acknowledge, or would drop the summary too early. It acknowledges again while the interrupt is still active, where a design that ignored the active state would hand the same interrupt out twice. It also sets and clears one bit in the same cycle, through both the raise path and the write ports, where a clear-wins update would silently drop a fresh request.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int SGI_MAX_CPU = 8;

  // Flat position of a per-source pending bit; the sources of one
  // (interrupt, target) pair sit next to each other.
  function automatic int bit_pos(int id, int tgt, int src, int ncpu);
    return (id * ncpu + tgt) * ncpu + src;
  endfunction
endpackage

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank #(
  parameter int NCPU = 4,
  parameter int NSGI = 16,
  localparam int SW = $clog2(NCPU),
  localparam int IW = $clog2(NSGI),
  localparam int NB = NSGI * NCPU * NCPU
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rq_fire,
  input  logic [SW-1:0]    rq_src,
  input  logic [IW-1:0]    rq_id,
  input  logic [NCPU-1:0]  rq_tgt,
  input  logic             sp_valid,
  input  logic [IW-1:0]    sp_id,
  input  logic [SW-1:0]    sp_src,
  input  logic [SW-1:0]    sp_tgt,
  input  logic             cp_valid,
  input  logic [IW-1:0]    cp_id,
  input  logic [SW-1:0]    cp_src,
  input  logic [SW-1:0]    cp_tgt,
  input  logic [NCPU-1:0]  ack_clr,
  input  logic [NCPU*IW-1:0] ack_id,
  input  logic [NCPU*SW-1:0] ack_src,
  output logic [NB-1:0]    pend_q
);
  logic [NB-1:0] set_v;
  logic [NB-1:0] clr_v;

  for (genvar gi = 0; gi < NSGI; gi++) begin : g_id
    for (genvar gt = 0; gt < NCPU; gt++) begin : g_tgt
      for (genvar gs = 0; gs < NCPU; gs++) begin : g_src
        localparam int K = sgi_pkg::bit_pos(gi, gt, gs, NCPU);
        assign set_v[K] =
          (rq_fire && rq_tgt[gt] && rq_id == IW'(gi) && rq_src == SW'(gs)) ||
          (sp_valid && sp_id == IW'(gi) && sp_src == SW'(gs) && sp_tgt == SW'(gt));
        assign clr_v[K] =
          (cp_valid && cp_id == IW'(gi) && cp_src == SW'(gs) && cp_tgt == SW'(gt)) ||
          (ack_clr[gt] && ack_id[gt*IW +: IW] == IW'(gi) &&
           ack_src[gt*SW +: SW] == SW'(gs));
      end
    end
  end

  // set after clear: a fresh request survives a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_v) | set_v;
  end
endmodule

// File: rtl/sgi_ack_pick.sv
module sgi_ack_pick #(
  parameter int NCPU = 4,
  parameter int NSGI = 16,
  localparam int SW = $clog2(NCPU),
  localparam int IW = $clog2(NSGI)
) (
  input  logic [NSGI*NCPU-1:0] pend_t,   // index id*NCPU+src, one target
  input  logic [NSGI-1:0]      act_t,
  output logic [NSGI-1:0]      sum_t,
  output logic                 hit,
  output logic [IW-1:0]        id,
  output logic [SW-1:0]        src
);
  for (genvar gi = 0; gi < NSGI; gi++) begin : g_sum
    assign sum_t[gi] = |pend_t[gi*NCPU +: NCPU];
  end

  always_comb begin
    hit = 1'b0;
    id  = '0;
    src = '0;
    for (int i = NSGI - 1; i >= 0; i--) begin
      if (sum_t[i] && !act_t[i]) begin
        hit = 1'b1;
        id  = IW'(i);
      end
    end
    for (int s = NCPU - 1; s >= 0; s--) begin
      if (hit && pend_t[int'(id) * NCPU + s]) src = SW'(s);
    end
  end
endmodule

// File: rtl/sgi_ack_unit.sv
module sgi_ack_unit #(
  parameter int NCPU = 4,
  parameter int NSGI = 16,
  localparam int SW = $clog2(NCPU),
  localparam int IW = $clog2(NSGI)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ack_req,
  input  logic            eoi_valid,
  input  logic [IW-1:0]   eoi_id,
  input  logic            pick_hit,
  input  logic [IW-1:0]   pick_id,
  input  logic [SW-1:0]   pick_src,
  output logic            clr_en,
  output logic [NSGI-1:0] act_q,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [IW-1:0]   rsp_id,
  output logic [SW-1:0]   rsp_src
);
  logic [NSGI-1:0] eoi_vec;
  logic [NSGI-1:0] go_vec;

  assign clr_en = ack_req && pick_hit;

  always_comb begin
    for (int i = 0; i < NSGI; i++) begin
      eoi_vec[i] = eoi_valid && (eoi_id == IW'(i));
      go_vec[i]  = clr_en && (pick_id == IW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_id    <= '0;
      rsp_src   <= '0;
    end else begin
      act_q     <= (act_q & ~eoi_vec) | go_vec;
      rsp_valid <= ack_req;
      rsp_hit   <= clr_en;
      rsp_id    <= clr_en ? pick_id : '0;
      rsp_src   <= clr_en ? pick_src : '0;
    end
  end
endmodule

// File: rtl/sgi_pend_tracker.sv
module sgi_pend_tracker #(
  parameter int NCPU = 4,
  parameter int NSGI = 16,
  localparam int SW = $clog2(NCPU),
  localparam int IW = $clog2(NSGI),
  localparam int NB = NSGI * NCPU * NCPU
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rq_valid,
  output logic                 rq_ready,
  input  logic [SW-1:0]        rq_src,
  input  logic [IW-1:0]        rq_id,
  input  logic [NCPU-1:0]      rq_tgt,
  input  logic                 sp_valid,
  input  logic [IW-1:0]        sp_id,
  input  logic [SW-1:0]        sp_src,
  input  logic [SW-1:0]        sp_tgt,
  input  logic                 cp_valid,
  input  logic [IW-1:0]        cp_id,
  input  logic [SW-1:0]        cp_src,
  input  logic [SW-1:0]        cp_tgt,
  input  logic [NCPU-1:0]      ack_req,
  output logic [NCPU-1:0]      rsp_valid,
  output logic [NCPU-1:0]      rsp_hit,
  output logic [NCPU*IW-1:0]   rsp_id,
  output logic [NCPU*SW-1:0]   rsp_src,
  input  logic [NCPU-1:0]      eoi_valid,
  input  logic [NCPU*IW-1:0]   eoi_id,
  output logic [NSGI*NCPU-1:0] pend_sum,
  output logic [NSGI*NCPU-1:0] act
);
  logic [NB-1:0]                          pend_q;
  logic [NCPU-1:0][NSGI*NCPU-1:0]         pend_by_t;
  logic [NCPU-1:0][NSGI-1:0]              sum_by_t;
  logic [NCPU-1:0][NSGI-1:0]              act_by_t;
  logic [NCPU-1:0]                        pick_hit;
  logic [NCPU*IW-1:0]                     pick_id;
  logic [NCPU*SW-1:0]                     pick_src;
  logic [NCPU-1:0]                        clr_en;

  assign rq_ready = 1'b1;

  sgi_pend_bank #(.NCPU(NCPU), .NSGI(NSGI)) i_bank (
    .clk(clk), .rst(rst),
    .rq_fire(rq_valid && rq_ready), .rq_src(rq_src), .rq_id(rq_id), .rq_tgt(rq_tgt),
    .sp_valid(sp_valid), .sp_id(sp_id), .sp_src(sp_src), .sp_tgt(sp_tgt),
    .cp_valid(cp_valid), .cp_id(cp_id), .cp_src(cp_src), .cp_tgt(cp_tgt),
    .ack_clr(clr_en), .ack_id(pick_id), .ack_src(pick_src),
    .pend_q(pend_q)
  );

  for (genvar gt = 0; gt < NCPU; gt++) begin : g_cpu
    for (genvar gi = 0; gi < NSGI; gi++) begin : g_map
      assign pend_by_t[gt][gi*NCPU +: NCPU] =
        pend_q[sgi_pkg::bit_pos(gi, gt, 0, NCPU) +: NCPU];
      assign pend_sum[gi*NCPU + gt] = sum_by_t[gt][gi];
      assign act[gi*NCPU + gt]      = act_by_t[gt][gi];
    end

    sgi_ack_pick #(.NCPU(NCPU), .NSGI(NSGI)) i_pick (
      .pend_t(pend_by_t[gt]), .act_t(act_by_t[gt]), .sum_t(sum_by_t[gt]),
      .hit(pick_hit[gt]), .id(pick_id[gt*IW +: IW]), .src(pick_src[gt*SW +: SW])
    );

    sgi_ack_unit #(.NCPU(NCPU), .NSGI(NSGI)) i_unit (
      .clk(clk), .rst(rst), .ack_req(ack_req[gt]),
      .eoi_valid(eoi_valid[gt]), .eoi_id(eoi_id[gt*IW +: IW]),
      .pick_hit(pick_hit[gt]), .pick_id(pick_id[gt*IW +: IW]),
      .pick_src(pick_src[gt*SW +: SW]), .clr_en(clr_en[gt]),
      .act_q(act_by_t[gt]), .rsp_valid(rsp_valid[gt]), .rsp_hit(rsp_hit[gt]),
      .rsp_id(rsp_id[gt*IW +: IW]), .rsp_src(rsp_src[gt*SW +: SW])
    );
  end
endmodule

// File: rtl/sgi_pend_tracker_chk.sv
module sgi_pend_tracker_chk #(
  parameter int NCPU = 4,
  parameter int NSGI = 16,
  localparam int IW = $clog2(NSGI)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rq_valid,
  input logic                 sp_valid,
  input logic [NCPU-1:0]      ack_req,
  input logic [NCPU-1:0]      rsp_valid,
  input logic [NCPU-1:0]      rsp_hit,
  input logic [NCPU*IW-1:0]   rsp_id,
  input logic [NCPU-1:0]      eoi_valid,
  input logic [NCPU*IW-1:0]   eoi_id,
  input logic [NSGI*NCPU-1:0] pend_sum,
  input logic [NSGI*NCPU-1:0] act
);
  for (genvar gt = 0; gt < NCPU; gt++) begin : g_t
    // R6: response exactly one clock after request
    a_r6_rsp_follows: assert property (@(posedge clk) disable iff (rst)
      ack_req[gt] |=> rsp_valid[gt]);
    a_r6_rsp_quiet: assert property (@(posedge clk) disable iff (rst)
      !ack_req[gt] |=> !rsp_valid[gt]);
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid[gt] && !rsp_hit[gt]) |-> (rsp_id[gt*IW +: IW] == '0));
    // R7: a handed-out interrupt is active for that target
    a_r7_hit_active: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid[gt] && rsp_hit[gt]) |-> act[int'(rsp_id[gt*IW +: IW]) * NCPU + gt]);
    for (genvar gi = 0; gi < NSGI; gi++) begin : g_i
      // R7: active only drops on a matching end-of-interrupt
      a_r7_act_fall_eoi: assert property (@(posedge clk) disable iff (rst)
        $fell(act[gi*NCPU + gt]) |->
          $past(eoi_valid[gt] && eoi_id[gt*IW +: IW] == IW'(gi)));
      // R1, R3: summary only rises after a set through a write or raise
      a_r1_sum_rise_set: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_sum[gi*NCPU + gt]) |-> $past(rq_valid || sp_valid));
    end
  end
endmodule

bind sgi_pend_tracker sgi_pend_tracker_chk #(.NCPU(NCPU), .NSGI(NSGI)) i_chk (
  .clk(clk), .rst(rst), .rq_valid(rq_valid), .sp_valid(sp_valid),
  .ack_req(ack_req), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_id(rsp_id),
  .eoi_valid(eoi_valid), .eoi_id(eoi_id), .pend_sum(pend_sum), .act(act)
);

// File: tb/test_sgi_pend_tracker.sv
module test_sgi_pend_tracker;
  localparam int NCPU = 4;
  localparam int NSGI = 16;
  localparam int SW = 2;
  localparam int IW = 4;
  localparam int NS = NSGI * NCPU;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic rq_valid, rq_ready;
  logic [SW-1:0] rq_src;
  logic [IW-1:0] rq_id;
  logic [NCPU-1:0] rq_tgt;
  logic sp_valid, cp_valid;
  logic [IW-1:0] sp_id, cp_id;
  logic [SW-1:0] sp_src, sp_tgt, cp_src, cp_tgt;
  logic [NCPU-1:0] ack_req, rsp_valid, rsp_hit, eoi_valid;
  logic [NCPU*IW-1:0] rsp_id, eoi_id;
  logic [NCPU*SW-1:0] rsp_src;
  logic [NS-1:0] pend_sum, act;

  sgi_pend_tracker #(.NCPU(NCPU), .NSGI(NSGI)) i_sgi_pend_tracker (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  bit mp [NSGI][NCPU][NCPU];   // [id][src][tgt]
  bit ma [NSGI][NCPU];         // [id][tgt]
  int checks = 0;
  int errors = 0;

  task automatic chk(bit ok, string req, string what, longint unsigned a, longint unsigned e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, a, e);
    end
  endtask

  function automatic bit msum(int i, int t);
    bit r = 0;
    for (int s = 0; s < NCPU; s++) r |= mp[i][s][t];
    return r;
  endfunction

  function automatic logic [NS-1:0] msum_vec();
    logic [NS-1:0] v;
    for (int i = 0; i < NSGI; i++) for (int t = 0; t < NCPU; t++) v[i*NCPU+t] = msum(i, t);
    return v;
  endfunction

  function automatic logic [NS-1:0] mact_vec();
    logic [NS-1:0] v;
    for (int i = 0; i < NSGI; i++) for (int t = 0; t < NCPU; t++) v[i*NCPU+t] = ma[i][t];
    return v;
  endfunction

  task automatic idle();
    rq_valid = 0; rq_src = 0; rq_id = 0; rq_tgt = 0;
    sp_valid = 0; sp_id = 0; sp_src = 0; sp_tgt = 0;
    cp_valid = 0; cp_id = 0; cp_src = 0; cp_tgt = 0;
    ack_req = 0; eoi_valid = 0; eoi_id = 0;
  endtask

  // One clock: predict, advance, compare everything against the model.
  task automatic step();
    bit nmp [NSGI][NCPU][NCPU];
    bit nma [NSGI][NCPU];
    bit eh [NCPU];
    int ei [NCPU];
    int es [NCPU];
    logic [NCPU-1:0] ereq;
    nmp = mp; nma = ma; ereq = ack_req;
    for (int t = 0; t < NCPU; t++) begin
      eh[t] = 0; ei[t] = 0; es[t] = 0;
      if (ack_req[t]) begin
        for (int i = NSGI - 1; i >= 0; i--) if (msum(i, t) && !ma[i][t]) begin eh[t] = 1; ei[t] = i; end
        if (eh[t]) for (int s = NCPU - 1; s >= 0; s--) if (mp[ei[t]][s][t]) es[t] = s;
      end
      if (eoi_valid[t]) nma[eoi_id[t*IW +: IW]][t] = 0;
      if (eh[t]) begin nmp[ei[t]][es[t]][t] = 0; nma[ei[t]][t] = 1; end
    end
    if (cp_valid) nmp[cp_id][cp_src][cp_tgt] = 0;
    if (rq_valid) for (int t = 0; t < NCPU; t++) if (rq_tgt[t]) nmp[rq_id][rq_src][t] = 1;
    if (sp_valid) nmp[sp_id][sp_src][sp_tgt] = 1;
    @(posedge clk); #1;
    mp = nmp; ma = nma;
    chk(pend_sum == msum_vec(), "R2", "pend_sum", pend_sum, msum_vec());
    chk(act == mact_vec(), "R7", "act", act, mact_vec());
    for (int t = 0; t < NCPU; t++) begin
      chk(rsp_valid[t] == ereq[t], "R6", "rsp_valid", rsp_valid[t], ereq[t]);
      if (ereq[t]) begin
        chk(rsp_hit[t] == eh[t], "R4", "rsp_hit", rsp_hit[t], eh[t]);
        chk(rsp_id[t*IW +: IW] == IW'(ei[t]), "R4", "rsp_id", rsp_id[t*IW +: IW], ei[t]);
        chk(rsp_src[t*SW +: SW] == SW'(es[t]), "R4", "rsp_src", rsp_src[t*SW +: SW], es[t]);
      end
    end
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(pend_sum == 0 && act == 0 && rsp_valid == 0, "R9", "reset state", {pend_sum, act}, 0);
    chk(rq_ready == 1, "R1", "rq_ready", rq_ready, 1);
    rst = 0;

    // R1/R2: two sources raise interrupt 5 toward target 0
    rq_valid = 1; rq_id = 5; rq_src = 1; rq_tgt = 4'b0001;
    sp_valid = 1; sp_id = 5; sp_src = 3; sp_tgt = 0;
    step();
    chk(pend_sum[5*NCPU+0] == 1, "R1", "raise sets", pend_sum[5*NCPU], 1);
    chk(pend_sum[5*NCPU+1] == 0, "R1", "untargeted cpu", pend_sum[5*NCPU+1], 0);
    ack_req = 4'b0001; step();
    chk(rsp_hit[0] && rsp_id[3:0] == 5 && rsp_src[1:0] == 1, "R4", "lowest source", rsp_src[1:0], 1);
    chk(pend_sum[5*NCPU+0] == 1, "R5", "summary kept after partial ack", pend_sum[5*NCPU], 1);
    chk(act[5*NCPU+0] == 1, "R7", "active after ack", act[5*NCPU], 1);
    ack_req = 4'b0001; step();
    chk(rsp_hit[0] == 0 && rsp_id[3:0] == 0, "R7", "active not re-presented", rsp_hit[0], 0);
    eoi_valid = 4'b0001; eoi_id = {12'h0, 4'd5}; step();
    chk(act[5*NCPU+0] == 0, "R7", "eoi clears", act[5*NCPU], 0);
    ack_req = 4'b0001; step();
    chk(rsp_hit[0] && rsp_src[1:0] == 3, "R4", "second source", rsp_src[1:0], 3);
    chk(pend_sum[5*NCPU+0] == 0, "R2", "summary drops", pend_sum[5*NCPU], 0);
    eoi_valid = 4'b0001; eoi_id = {12'h0, 4'd5}; step();

    // R8: raise collides with the acknowledge that clears the same bit
    rq_valid = 1; rq_id = 2; rq_src = 0; rq_tgt = 4'b0010; step();
    ack_req = 4'b0010; rq_valid = 1; rq_id = 2; rq_src = 0; rq_tgt = 4'b0010; step();
    chk(rsp_hit[1] && rsp_id[7:4] == 2, "R8", "ack taken", rsp_id[7:4], 2);
    chk(pend_sum[2*NCPU+1] == 1, "R8", "set beats ack clear", pend_sum[2*NCPU+1], 1);
    cp_valid = 1; cp_id = 2; cp_src = 0; cp_tgt = 1; step();
    chk(pend_sum[2*NCPU+1] == 0, "R3", "clear port", pend_sum[2*NCPU+1], 1'b0);
    sp_valid = 1; cp_valid = 1; sp_id = 2; cp_id = 2; sp_tgt = 1; cp_tgt = 1; step();
    chk(pend_sum[2*NCPU+1] == 1, "R8", "set beats clear port", pend_sum[2*NCPU+1], 1);
    sp_valid = 1; sp_id = 7; sp_src = 2; sp_tgt = 3; step();
    cp_valid = 1; cp_id = 7; cp_src = 1; cp_tgt = 3; step();
    chk(pend_sum[7*NCPU+3] == 1, "R3", "other-source clear ignored", pend_sum[7*NCPU+3], 1);

    // constrained random traffic
    for (int n = 0; n < 5000; n++) begin
      rq_valid = ($urandom % 100) < 35;
      rq_id = IW'($urandom % 6); rq_src = SW'($urandom); rq_tgt = NCPU'($urandom);
      sp_valid = ($urandom % 100) < 15;
      sp_id = IW'($urandom % 6); sp_src = SW'($urandom); sp_tgt = SW'($urandom);
      cp_valid = ($urandom % 100) < 20;
      cp_id = IW'($urandom % 6); cp_src = SW'($urandom); cp_tgt = SW'($urandom);
      ack_req = NCPU'($urandom) & NCPU'($urandom);
      for (int t = 0; t < NCPU; t++) begin
        eoi_valid[t] = ($urandom % 2) == 1;
        eoi_id[t*IW +: IW] = IW'($urandom);
        for (int i = NSGI - 1; i >= 0; i--) if (ma[i][t] && ($urandom % 4) != 0) eoi_id[t*IW +: IW] = IW'(i);
      end
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule